// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block connects a CPU data-space request port to an external parallel SRAM bus. On that bus one 8-bit port carries the low address byte first and then the data, and a second 8-bit port carries the high address byte. An address-latch strobe (ALE) marks the address phase, and separate read and write strobes mark the data phase. Each request names a 16-bit address. If the address falls in the internal region, the block completes the request in one cycle and leaves the bus alone. Otherwise it runs a multi-cycle external transfer.

External space is split at a programmable boundary into a lower and an upper sector. Each sector has its own 2-bit wait code, which sets how long the read or write strobe stays active. When a transfer finishes, the block returns a one-cycle ready pulse. During the final period it raises ALE once more only if the CPU signals that its next access also targets RAM. An optional bus keeper makes the multiplexed port keep driving the last transferred byte between transfers.

The controller is a state machine with five states. ST_IDLE waits for a request. ST_INTL is the one-cycle internal completion. ST_ADDR is the address phase (T1). ST_STRB is the strobe phase, which lasts one or more periods. ST_DONE is the final period. The transitions are as follows. ST_IDLE goes to ST_INTL on an internal request and to ST_ADDR on an external request. ST_INTL goes to ST_IDLE. ST_ADDR goes to ST_STRB. ST_STRB stays in ST_STRB until the strobe counter runs out, then goes to ST_DONE. ST_DONE goes to ST_IDLE.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: A request whose address is below 0x1100 completes with `req_ready` high in the cycle after acceptance. It raises no ALE, read strobe or write strobe.
- R2: An external address at or above `cfg_sector_base` uses `cfg_wait_hi`. An external address below it uses `cfg_wait_lo`. A boundary of 0x1100 puts all of external space in the upper sector.
- R3: An external transfer lasts 3, 4, 6 or 7 periods for wait codes 00, 01, 10 and 11. These periods are one address period, then 1, 2, 4 or 5 strobe periods, then one final period.
- R4: In the first period ALE is high and the multiplexed port drives address bits 7:0. `bus_ahi` shows address bits 15:8 in every period of the transfer.
- R5: During a write, the write strobe is high for every strobe period and the multiplexed port drives the write data. The read strobe stays low.
- R6: During a read, the read strobe is high for every strobe period and the multiplexed port is released. The block samples `bus_ad_in` at the clock edge that ends the strobe and presents it on `req_rdata` from the ready cycle onward.
- R7: In the final period of an external transfer, ALE is high exactly when `nxt_ram` is high.
- R8: Between transfers, `bus_ad_oe` equals `cfg_keeper`. With the keeper on, `bus_ad_out` holds the last byte written or read.
- R9: `req_ready` is a single-cycle pulse that coincides with the final period.
- R10: A `req_valid` that arrives while a transfer is in progress is ignored and starts no later transfer.
- R11: After reset with the keeper off, all strobes and `req_ready` are low and the multiplexed port is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write data |
| nxt_ram | input | 1 | The next CPU access targets RAM |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Last read data |
| cfg_wait_lo | input | 2 | Wait code, lower sector |
| cfg_wait_hi | input | 2 | Wait code, upper sector |
| cfg_sector_base | input | 16 | First address of the upper sector |
| cfg_keeper | input | 1 | Keep driving the last data while idle |
| bus_ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_ahi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Multiplexed port output value |
| bus_ad_oe | output | 1 | Multiplexed port output enable |
| bus_ad_in | input | 8 | Multiplexed port input value |

## Verification
The hardest case to reach is a request that arrives while a long transfer is still in its strobe phase. A correct design drops it without trace. A faulty one either queues it or cuts the strobe short. The bench starts a six-period read and pulses an internal-address request in the middle of the strobe phase. It then checks that the read still lasts six periods and that no ready pulse or ALE follows afterwards. The sector boundary is probed at both edges, at 0x1100 and at one address below 0x8000, with different wait codes on each side, so that choosing the wrong sector changes the measured length.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INTL,
        ST_ADDR,
        ST_STRB,
        ST_DONE
    } xmb_state_e;

    // strobe periods per wait code: 00->1, 01->2, 10->4, 11->5
    function automatic logic [2:0] strobe_len(input logic [1:0] code);
        logic [2:0] n;
        unique case (code)
            2'b00: n = 3'd1;
            2'b01: n = 3'd2;
            2'b10: n = 3'd4;
            default: n = 3'd5;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/xmb_decode.sv
module xmb_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] EXT_BASE = 16'h1100
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] sector_base,
    input  logic [1:0]    wait_lo,
    input  logic [1:0]    wait_hi,
    output logic          is_ext,
    output logic [1:0]    wcode
);
    always_comb begin
        is_ext = (addr >= EXT_BASE);
        wcode  = (addr >= sector_base) ? wait_hi : wait_lo;
    end
endmodule

// File: rtl/xmb_wait_ctr.sv
module xmb_wait_ctr #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          en,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (en && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
    import xmb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] EXT_BASE = 16'h1100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          nxt_ram,
    output logic          req_ready,
    output logic [DW-1:0] req_rdata,
    input  logic [1:0]    cfg_wait_lo,
    input  logic [1:0]    cfg_wait_hi,
    input  logic [AW-1:0] cfg_sector_base,
    input  logic          cfg_keeper,
    output logic          bus_ale,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [AW-DW-1:0] bus_ahi,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    input  logic [DW-1:0] bus_ad_in
);
    localparam int CW = 3;

    xmb_state_e    state, state_nx;
    logic [AW-1:0] addr_q;
    logic          wr_q;
    logic [DW-1:0] wd_q, keep_q, rdata_q;
    logic          is_ext, accept, strb_last;
    logic [1:0]    wcode;
    logic [CW-1:0] len_m1;

    xmb_decode #(.AW(AW), .EXT_BASE(EXT_BASE)) u_dec (
        .addr        (req_addr),
        .sector_base (cfg_sector_base),
        .wait_lo     (cfg_wait_lo),
        .wait_hi     (cfg_wait_hi),
        .is_ext      (is_ext),
        .wcode       (wcode)
    );

    assign accept = (state == ST_IDLE) && req_valid;
    assign len_m1 = strobe_len(wcode) - 3'd1;

    xmb_wait_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (len_m1),
        .en       (state == ST_STRB),
        .last     (strb_last)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = is_ext ? ST_ADDR : ST_INTL;
            ST_INTL: state_nx = ST_IDLE;
            ST_ADDR: state_nx = ST_STRB;
            ST_STRB: if (strb_last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wd_q    <= '0;
            keep_q  <= '0;
            rdata_q <= '0;
        end else begin
            state <= state_nx;
            if (accept && is_ext) begin
                addr_q <= req_addr;
                wr_q   <= req_write;
                wd_q   <= req_wdata;
            end
            if (state == ST_STRB && strb_last) begin
                if (wr_q) begin
                    keep_q <= wd_q;
                end else begin
                    keep_q  <= bus_ad_in;
                    rdata_q <= bus_ad_in;
                end
            end
        end
    end

    // outputs
    always_comb begin
        bus_ale    = 1'b0;
        bus_rd     = 1'b0;
        bus_wr     = 1'b0;
        bus_ad_oe  = cfg_keeper;
        bus_ad_out = keep_q;
        req_ready  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_INTL: req_ready = 1'b1;
            ST_ADDR: begin
                bus_ale    = 1'b1;
                bus_ad_oe  = 1'b1;
                bus_ad_out = addr_q[DW-1:0];
            end
            ST_STRB: begin
                bus_rd     = !wr_q;
                bus_wr     = wr_q;
                bus_ad_oe  = wr_q;
                bus_ad_out = wd_q;
            end
            ST_DONE: begin
                req_ready = 1'b1;
                bus_ale   = nxt_ram;
            end
            default: ;
        endcase
    end

    assign bus_ahi   = addr_q[AW-1:DW];
    assign req_rdata = rdata_q;

endmodule

// File: rtl/xmb_chk.sv
module xmb_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ale,
    input logic bus_rd,
    input logic bus_wr,
    input logic bus_ad_oe,
    input logic req_ready,
    input logic cfg_keeper
);
    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R4
    strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd) || $rose(bus_wr)) |-> $past(bus_ale));

    // R4
    addr_phase_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && !req_ready) |=> (bus_rd || bus_wr));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R6
    rd_end_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd) |-> req_ready);

    // R6
    rd_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !bus_ad_oe);

    // R5
    wr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_ad_oe);

    // R8
    keeper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ale && !bus_rd && !bus_wr) |-> (bus_ad_oe == cfg_keeper));
endmodule

bind xmem_bus_ctrl xmb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ale    (bus_ale),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_ad_oe  (bus_ad_oe),
    .req_ready  (req_ready),
    .cfg_keeper (cfg_keeper)
);

// File: tb/xmem_bus_ctrl_bench.sv
module xmem_bus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, nxt_ram = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic [1:0]  cfg_wait_lo = '0, cfg_wait_hi = '0;
    logic [15:0] cfg_sector_base = 16'h8000;
    logic        cfg_keeper = 1'b0;
    logic        bus_ale, bus_rd, bus_wr, bus_ad_oe;
    logic [7:0]  bus_ahi, bus_ad_out;
    logic [7:0]  bus_ad_in = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    xmem_bus_ctrl u_xmem_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .nxt_ram(nxt_ram),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
        .cfg_sector_base(cfg_sector_base), .cfg_keeper(cfg_keeper),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ahi(bus_ahi),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rin;
        logic [1:0]  wlo;
        logic [1:0]  whi;
        logic [15:0] base;
        logic        keep;
        logic        nram;
        logic [3:0]  len;
        logic [3:0]  strb;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h2000, 8'h00, 8'hA5, 2'b00, 2'b11, 16'h8000, 1'b0, 1'b0, 4'd3, 4'd1},
        '{1'b1, 16'h2034, 8'h3C, 8'h00, 2'b01, 2'b11, 16'h8000, 1'b1, 1'b1, 4'd4, 4'd2},
        '{1'b0, 16'h9012, 8'h00, 8'h5A, 2'b00, 2'b10, 16'h8000, 1'b1, 1'b1, 4'd6, 4'd4},
        '{1'b1, 16'hFFFF, 8'hC3, 8'h00, 2'b00, 2'b11, 16'h8000, 1'b0, 1'b0, 4'd7, 4'd5},
        '{1'b0, 16'h1100, 8'h00, 8'h77, 2'b11, 2'b00, 16'h1100, 1'b1, 1'b0, 4'd3, 4'd1},
        '{1'b0, 16'h7FFF, 8'h00, 8'h81, 2'b10, 2'b00, 16'h8000, 1'b0, 1'b1, 4'd6, 4'd4},
        '{1'b0, 16'h10FF, 8'h00, 8'h00, 2'b11, 2'b11, 16'h8000, 1'b0, 1'b1, 4'd1, 4'd0},
        '{1'b1, 16'h0000, 8'h99, 8'h00, 2'b11, 2'b11, 16'h8000, 1'b1, 1'b1, 4'd1, 4'd0},
        '{1'b1, 16'h8000, 8'h42, 8'h00, 2'b11, 2'b01, 16'h8000, 1'b1, 1'b0, 4'd4, 4'd2}
    };

    task automatic run_vec(input vec_t v);
        bit ext;
        int n;
        int strb;
        ext = (v.addr >= 16'h1100);
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wd;
        bus_ad_in = v.rin; cfg_wait_lo = v.wlo; cfg_wait_hi = v.whi;
        cfg_sector_base = v.base; cfg_keeper = v.keep; nxt_ram = v.nram;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; strb = 0;
        // first observed period
        check(bus_ale == ext, "R1/R4 first-period ALE", bus_ale, ext);
        if (ext) begin
            check(bus_ad_oe && bus_ad_out == v.addr[7:0], "R4 address low byte", bus_ad_out, v.addr[7:0]);
        end
        while (!req_ready && n < 20) begin
            @(negedge clk);
            n++;
            if (!req_ready) begin
                if (bus_rd || bus_wr) strb++;
                check(bus_ahi == v.addr[15:8], "R4 high address byte", bus_ahi, v.addr[15:8]);
                if (v.wr) begin
                    check(bus_wr && !bus_rd && bus_ad_oe && bus_ad_out == v.wd,
                          "R5 write strobe and data", bus_ad_out, v.wd);
                end else begin
                    check(bus_rd && !bus_wr && !bus_ad_oe, "R6 read strobe, port released",
                          {bus_rd, bus_ad_oe}, 2'b10);
                end
            end
        end
        check(n == int'(v.len), "R3/R2/R1 transfer length", n, v.len);
        check(strb == int'(v.strb), "R3 strobe periods", strb, v.strb);
        check(bus_ale == (ext && v.nram), "R7 final-period ALE", bus_ale, ext && v.nram);
        if (ext && !v.wr) begin
            check(req_rdata == v.rin, "R6 read data", req_rdata, v.rin);
        end
        @(negedge clk);
        check(!req_ready, "R9 ready single pulse", req_ready, 0);
        check(bus_ad_oe == v.keep, "R8 keeper enable", bus_ad_oe, v.keep);
        if (ext && v.keep) begin
            check(bus_ad_out == (v.wr ? v.wd : v.rin), "R8 kept data", bus_ad_out, v.wr ? v.wd : v.rin);
        end
    endtask

    initial begin
        #(4 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!bus_ale && !bus_rd && !bus_wr && !req_ready && !bus_ad_oe,
              "R11 reset outputs", {bus_ale, bus_rd, bus_wr, req_ready, bus_ad_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_ale && !req_ready, "R11 idle after reset", {bus_ale, req_ready}, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10 request during a transfer is ignored
        @(negedge clk);
        cfg_keeper = 1'b0; cfg_wait_lo = 2'b10; cfg_sector_base = 16'h8000; nxt_ram = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h3000; bus_ad_in = 8'h6E;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int n;
            n = 1;
            @(negedge clk); n++;
            req_valid = 1'b1; req_addr = 16'h0005; req_write = 1'b1;
            @(negedge clk); n++;
            req_valid = 1'b0;
            while (!req_ready && n < 20) begin
                @(negedge clk); n++;
            end
            check(n == 6, "R10 busy transfer length kept", n, 6);
            check(req_rdata == 8'h6E, "R10 read data intact", req_rdata, 8'h6E);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(!req_ready && !bus_ale && !bus_rd && !bus_wr, "R10 no trailing activity",
                      {req_ready, bus_ale, bus_rd, bus_wr}, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule